// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that cannot be stopped once started. Software controls it through a small register window of four 32-bit words. Writing a 16-bit magic value to the key word performs one of three actions. One value opens the configuration words for writing. One value starts the countdown. One value refreshes the counter.

The countdown runs on a slow tick, given to the block as a one-clock-cycle enable pulse on the system clock. A selectable divider scales the tick. A down-counter of `CNT_W` bits then counts the divided steps. When the counter runs out, the block pulses a reset-request output for one cycle and starts a new period.

New divider and reload settings do not apply at once. Each takes effect a fixed number of ticks (`SYNC_TICKS`) after it is written. Two status bits show which updates are still waiting.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the divider word reads 0, the reload word reads all ones, the status word reads 0, and the key word always reads 0. No reset request is raised, whatever the ticks, until the start key has been written.
- R2: A write to the divider word (index 1) or the reload word (index 2) is ignored unless the open key 0x5555 was the most recent key-word (index 0) write. An ignored write leaves the read-back value and the status unchanged.
- R3: Any key-word write whose full 32-bit value is not 0x5555 closes write access to the configuration words again.
- R4: An accepted divider write sets status bit 0, and an accepted reload write sets status bit 1 (status word, index 3). Each bit clears on the `SYNC_TICKS`-th tick after its latest write.
- R5: Writing the start key 0xCCCC starts the countdown. With divider D and reload value L in force, the first reset request comes on tick (L+1)*D after the start. The request lasts exactly one clock cycle.
- R6: Divider codes 0 to 6 select D = 4, 8, 16, 32, 64, 128 and 256. Code 7 also selects 256.
- R7: Writing the refresh key 0xAAAA reloads the counter and clears the divider phase. The next request then comes (L+1)*D ticks after the refresh.
- R8: After each request the counter reloads by itself, so requests repeat every (L+1)*D ticks.
- R9: Once started, only the reset input stops the countdown. A second start key does not restart or change the period.
- R10: A divider or reload value comes into use only when its pending status bit clears. Until then the previous value governs the countdown and any reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per slow tick |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_idx | input | 2 | Word index: 0 key, 1 divider, 2 reload, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_idx |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with `CNT_W` = 12 and `SYNC_TICKS` = 2. The two-tick update latency lets a test observe a pending bit and its clearing within a few ticks. It also lets a test start the countdown while a reload update is still waiting, which shows the old value governing the first period and the new one the second. Small reload values keep every divider code, up to 256, within a few hundred ticks, so each code is timed exactly.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int CNT_W      = 12,
  parameter int SYNC_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_idx,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req
);

  localparam int LAT_W = $clog2(SYNC_TICKS + 1);
  localparam logic [31:0] KEY_OPEN = 32'h0000_5555;
  localparam logic [31:0] KEY_GO   = 32'h0000_CCCC;
  localparam logic [31:0] KEY_FEED = 32'h0000_AAAA;
  localparam logic [LAT_W-1:0] LAT_INIT = LAT_W'(SYNC_TICKS);

  logic             unlock_q, run_q;
  logic [2:0]       pr_q, pr_act;
  logic [CNT_W-1:0] rl_q, rl_act, cnt_q;
  logic             pr_pend, rl_pend;
  logic [LAT_W-1:0] pr_lat, rl_lat;
  logic [7:0]       div_cnt, div_lim;

  wire wr     = bus_sel & bus_wr;
  wire wr_key = wr & (bus_idx == 2'd0);
  wire wr_pr  = wr & (bus_idx == 2'd1) & unlock_q;
  wire wr_rl  = wr & (bus_idx == 2'd2) & unlock_q;
  wire go     = wr_key & (bus_wdata == KEY_GO) & ~run_q;
  wire feed   = wr_key & (bus_wdata == KEY_FEED);

  always_ff @(posedge clk) begin
    if (!rst_n)      unlock_q <= 1'b0;
    else if (wr_key) unlock_q <= (bus_wdata == KEY_OPEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr_q    <= 3'd0;
      pr_act  <= 3'd0;
      pr_pend <= 1'b0;
      pr_lat  <= '0;
    end else if (wr_pr) begin
      pr_q    <= bus_wdata[2:0];
      pr_pend <= 1'b1;
      pr_lat  <= LAT_INIT;
    end else if (pr_pend && tick) begin
      pr_lat <= pr_lat - 1'b1;
      if (pr_lat == LAT_W'(1)) begin
        pr_act  <= pr_q;
        pr_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl_q    <= '1;
      rl_act  <= '1;
      rl_pend <= 1'b0;
      rl_lat  <= '0;
    end else if (wr_rl) begin
      rl_q    <= bus_wdata[CNT_W-1:0];
      rl_pend <= 1'b1;
      rl_lat  <= LAT_INIT;
    end else if (rl_pend && tick) begin
      rl_lat <= rl_lat - 1'b1;
      if (rl_lat == LAT_W'(1)) begin
        rl_act  <= rl_q;
        rl_pend <= 1'b0;
      end
    end
  end

  always_comb begin
    if (pr_act == 3'd7) div_lim = 8'd255;
    else                div_lim = 8'((16'd4 << pr_act) - 16'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '1;
      div_cnt <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (go) begin
        run_q   <= 1'b1;
        cnt_q   <= rl_act;
        div_cnt <= '0;
      end else if (feed) begin
        cnt_q   <= rl_act;
        div_cnt <= '0;
      end else if (run_q && tick) begin
        if (div_cnt >= div_lim) begin
          div_cnt <= '0;
          if (cnt_q == '0) begin
            rst_req <= 1'b1;
            cnt_q   <= rl_act;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_idx)
      2'd1:    bus_rdata = {29'd0, pr_q};
      2'd2:    bus_rdata = {{(32-CNT_W){1'b0}}, rl_q};
      2'd3:    bus_rdata = {30'd0, rl_pend, pr_pend};
      default: bus_rdata = 32'd0;
    endcase
  end

endmodule

module keyed_watchdog_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             rst_req,
  input logic             run_q,
  input logic             unlock_q,
  input logic [2:0]       pr_q,
  input logic [2:0]       pr_act,
  input logic             pr_pend,
  input logic [CNT_W-1:0] rl_q,
  input logic [CNT_W-1:0] rl_act,
  input logic             rl_pend
);

  // R5
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R1
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> run_q);

  // R9
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  // R2
  pr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pr_q) |-> $past(unlock_q));

  // R2
  rl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rl_q) |-> $past(unlock_q));

  // R10
  pr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pr_act) |-> $fell(pr_pend));

  // R10
  rl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rl_act) |-> $fell(rl_pend));

  // R4
  pend_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pr_pend) || $fell(rl_pend)) |-> $past(tick));

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rst_req(rst_req), .run_q(run_q),
  .unlock_q(unlock_q), .pr_q(pr_q), .pr_act(pr_act), .pr_pend(pr_pend),
  .rl_q(rl_q), .rl_act(rl_act), .rl_pend(rl_pend)
);

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_idx = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int tick_idx, pulses, first_at, last_at;
  int cycles = 0;

  always #2.5 clk = ~clk;

  keyed_watchdog #(.CNT_W(12), .SYNC_TICKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output int v);
    bus_idx = idx;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic pulse(input int n);
    tick_idx = 0; pulses = 0; first_at = -1; last_at = -1;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      tick_idx++;
      if (rst_req) begin
        pulses++;
        last_at = tick_idx;
        if (first_at < 0) first_at = tick_idx;
      end
    end
  endtask

  task automatic setup(input int code, input int rl);
    do_reset();
    wr(2'd0, 32'h5555);
    wr(2'd1, code);
    wr(2'd2, rl);
    pulse(2);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd(2'd1, v); chk(v == 0, "R1 divider", v, 0);
    rd(2'd2, v); chk(v == 'hFFF, "R1 reload", v, 'hFFF);
    rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
    wr(2'd0, 32'h5555);
    rd(2'd0, v); chk(v == 0, "R1 key reads zero", v, 0);
    wr(2'd0, 32'h0);
    pulse(300);
    chk(pulses == 0, "R1 idle no request", pulses, 0);
  endtask

  task automatic t_lock();
    int v;
    do_reset();
    wr(2'd1, 32'd5);
    rd(2'd1, v); chk(v == 0, "R2 locked divider", v, 0);
    rd(2'd3, v); chk(v == 0, "R2 locked status", v, 0);
    wr(2'd0, 32'h5555);
    wr(2'd0, 32'h1234);
    wr(2'd2, 32'd7);
    rd(2'd2, v); chk(v == 'hFFF, "R3 relocked reload", v, 'hFFF);
    wr(2'd0, 32'h5555);
    wr(2'd2, 32'd7);
    rd(2'd2, v); chk(v == 7, "R2 open reload", v, 7);
    rd(2'd3, v); chk(v == 2, "R4 reload pending", v, 2);
    pulse(1);
    rd(2'd3, v); chk(v == 2, "R4 still pending", v, 2);
    pulse(1);
    rd(2'd3, v); chk(v == 0, "R4 reload cleared", v, 0);
    wr(2'd1, 32'd2);
    rd(2'd3, v); chk(v == 1, "R4 divider pending", v, 1);
    wr(2'd2, 32'd9);
    rd(2'd3, v); chk(v == 3, "R4 both pending", v, 3);
    pulse(2);
    rd(2'd3, v); chk(v == 0, "R4 both cleared", v, 0);
  endtask

  task automatic t_period();
    setup(0, 3);
    wr(2'd0, 32'hCCCC);
    pulse(40);
    chk(first_at == 16, "R5 first expiry", first_at, 16);
    chk(pulses == 2, "R8 repeat count", pulses, 2);
    chk(last_at == 32, "R8 second expiry", last_at, 32);
  endtask

  task automatic t_div();
    for (int code = 0; code < 8; code++) begin
      int d;
      d = (code == 7) ? 256 : (4 << code);
      setup(code, 1);
      wr(2'd0, 32'hCCCC);
      pulse(2 * d);
      chk(first_at == 2 * d, "R6 divider timing", first_at, 2 * d);
      chk(pulses == 1, "R6 single request", pulses, 1);
    end
  endtask

  task automatic t_feed();
    setup(0, 3);
    wr(2'd0, 32'hCCCC);
    pulse(10);
    wr(2'd0, 32'hAAAA);
    pulse(16);
    chk(first_at == 16, "R7 refresh delays expiry", first_at, 16);
  endtask

  task automatic t_sticky();
    setup(0, 3);
    wr(2'd0, 32'hCCCC);
    pulse(5);
    wr(2'd0, 32'hCCCC);
    wr(2'd0, 32'h0);
    pulse(11);
    chk(first_at == 11, "R9 second start ignored", first_at, 11);
  endtask

  task automatic t_late();
    do_reset();
    wr(2'd0, 32'h5555);
    wr(2'd2, 32'd3);
    pulse(2);
    wr(2'd2, 32'd7);
    pulse(1);
    wr(2'd0, 32'hCCCC);
    pulse(48);
    chk(first_at == 16, "R10 old reload in first period", first_at, 16);
    chk(last_at == 48, "R10 new reload after commit", last_at, 48);
    chk(pulses == 2, "R10 request count", pulses, 2);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_period();
    t_div();
    t_feed();
    t_sticky();
    t_late();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule